// File: doc/BRIEF.md
# DMA Channel Address Sequencer

This block produces the address stream for one DMA channel. Software either programs a start address, a beat count and a signed 16-bit stride directly, or points the channel at a chain of parameter sets held in memory. After that, the block presents one address at a time to an external data mover. Each accepted beat advances the address by the stride and lowers the remaining count. The block does not move data, arbitrate for a bus, or pair channels. A memory-to-memory copy uses two instances: one generates the source addresses and the other generates the destination addresses.

There are four run modes. A linear run stops once the count is exhausted. An auto-reload run restores the programmed start address and count after every pass. A circular run does the same but raises a buffer-full interrupt instead of a completion interrupt. A chained run fetches four-word parameter sets from memory through a simple read port and starts each one without software help. Chaining stops at a parameter set whose last flag is set.

Top module: `dma_addr_seq`

## Requirements
- R1: After reset, `active`, `addr_valid`, `rd_req`, `done_irq` and `full_irq` are all low.
- R2: In linear mode (`cfg_mode` = 2'b00), a start with a nonzero count makes `addr_valid` rise on the next cycle with `addr` = `cfg_addr`. Each cycle with `addr_valid` and `beat` high consumes one address. After `cfg_count` beats, `addr_valid` falls, and `active` falls one cycle later.
- R3: Each consumed beat adds the sign-extended 16-bit stride to the address, modulo 2^AW. A zero stride repeats the same address.
- R4: `done_irq` is high for exactly the one cycle whose beat brings the count to zero, in linear, auto-reload and chained modes. It is never high without an accepted beat.
- R5: In auto-reload mode (2'b01), the beat that ends a pass reloads the programmed start address and count. The run continues with no idle cycle.
- R6: In circular mode (2'b10), reloading works as in R5, but the pass-ending beat pulses `full_irq` instead of `done_irq`. The two interrupts never coincide.
- R7: In chained mode (2'b11), the channel reads four words at `cfg_desc_ptr`, +4, +8 and +12. The words are, in order: the next-set pointer, the start address, the count (low CW bits), and a word with the stride in bits 15:0 and a last flag in bit 16. The run then starts. At its end, the channel fetches from the next-set pointer unless the last flag was set, in which case it stops.
- R8: A chained parameter set with a count of zero produces no beats and no interrupt. Chaining then proceeds according to its last flag.
- R9: `cfg_disable` takes effect at the next accepted beat, or at the end of a fetch in progress. The channel then returns to idle and presents no further addresses.
- R10: `cfg_start` is ignored while `active` is high. In the three register modes, a start with `cfg_count` = 0 is also ignored.
- R11: `rd_req` stays high with a stable `rd_addr` until `rd_valid` is seen. `rd_req` and `addr_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start | input | 1 | Start pulse, sampled only while idle |
| cfg_disable | input | 1 | Request to stop at the next beat boundary |
| cfg_mode | input | 2 | 00 linear, 01 auto-reload, 10 circular, 11 chained |
| cfg_addr | input | AW (32) | Start address for register modes |
| cfg_count | input | CW (16) | Beat count for register modes |
| cfg_stride | input | 16 | Signed address increment for register modes |
| cfg_desc_ptr | input | AW (32) | Address of the first parameter set in chained mode |
| beat | input | 1 | Data mover consumes the presented address this cycle |
| addr_valid | output | 1 | An address is presented |
| addr | output | AW (32) | Current address |
| done_irq | output | 1 | Completion pulse |
| full_irq | output | 1 | Circular buffer-full pulse |
| active | output | 1 | Channel is not idle |
| rd_req | output | 1 | Parameter word read request |
| rd_addr | output | AW (32) | Parameter word address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 32 | Read data word |

## Verification
Strides are drawn randomly and include zero and large negative values. A sequencer that extends the stride with zeros, or drops its top bit, would walk the wrong way and miss the expected address on the second beat. Reload and circular runs are pushed past a pass boundary with single-beat buffers as well. A design that reloads one beat late, or fires the wrong interrupt, would show a stale address or a misplaced pulse there. Chained runs include an empty middle set, a stall-prone read port and a cancel during the fetch. These expose a design that issues a beat for a zero count, fetches from the wrong offset, or ignores a stop request outside a run. A start pulse arriving mid-run must leave the address stream untouched.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_FETCH = 2'b01,
    ST_RUN   = 2'b10,
    ST_DONE  = 2'b11
  } seq_state_e;

  typedef enum logic [1:0] {
    MODE_LINEAR = 2'b00,
    MODE_RELOAD = 2'b01,
    MODE_CIRC   = 2'b10,
    MODE_DESC   = 2'b11
  } seq_mode_e;

  localparam int unsigned WORD_W        = 32;
  localparam int unsigned STRIDE_W      = 16;
  localparam int unsigned DESC_LAST_BIT = 16;
  localparam int unsigned DESC_WORDS    = 4;
  localparam int unsigned IDX_W         = $clog2(DESC_WORDS);
endpackage

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       disable_req,
  input  logic [1:0] mode_in,
  input  logic       cfg_count_zero,
  input  logic       beat,
  input  logic       count_is_one,
  input  logic       fetch_last,
  input  logic       desc_empty,
  input  logic       desc_last,
  output seq_state_e state_q,
  output seq_mode_e  mode_q,
  output logic       load_cfg,
  output logic       load_desc,
  output logic       fetch_start,
  output logic       beat_fire,
  output logic       term_beat
);
  seq_state_e state_d;
  seq_mode_e  mode_sel;
  logic       start_ok;
  logic       dis_eff;
  logic       dis_pend_q, dis_pend_d;
  logic       last_q;

  always_comb begin
    mode_sel    = seq_mode_e'(mode_in);
    start_ok    = (state_q == ST_IDLE) && start &&
                  ((mode_sel == MODE_DESC) || !cfg_count_zero);
    load_cfg    = start_ok && (mode_sel != MODE_DESC);
    fetch_start = start_ok && (mode_sel == MODE_DESC);
    dis_eff     = dis_pend_q || disable_req;
    beat_fire   = (state_q == ST_RUN) && beat;
    term_beat   = beat_fire && count_is_one;
    load_desc   = (state_q == ST_FETCH) && fetch_last && !dis_eff && !desc_empty;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_ok) state_d = (mode_sel == MODE_DESC) ? ST_FETCH : ST_RUN;
      end
      ST_FETCH: begin
        if (fetch_last) begin
          if (dis_eff)         state_d = ST_IDLE;
          else if (desc_empty) state_d = desc_last ? ST_DONE : ST_FETCH;
          else                 state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        if (beat_fire) begin
          if (dis_eff) begin
            state_d = ST_IDLE;
          end else if (count_is_one) begin
            unique case (mode_q)
              MODE_LINEAR: state_d = ST_DONE;
              MODE_DESC:   state_d = last_q ? ST_DONE : ST_FETCH;
              default:     state_d = ST_RUN;
            endcase
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    dis_pend_d = (state_q != ST_IDLE) && (state_d != ST_IDLE) && dis_eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      mode_q     <= MODE_LINEAR;
      last_q     <= 1'b0;
      dis_pend_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      dis_pend_q <= dis_pend_d;
      if (start_ok)  mode_q <= mode_sel;
      if (load_desc) last_q <= desc_last;
    end
  end
endmodule

// File: rtl/dma_seq_fetch.sv
module dma_seq_fetch
  import dma_seq_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fetch_start,
  input  logic [AW-1:0]       first_ptr,
  input  logic                in_fetch,
  input  logic                rd_valid,
  input  logic [WORD_W-1:0]   rd_data,
  output logic                rd_req,
  output logic [AW-1:0]       rd_addr,
  output logic                fetch_last,
  output logic                desc_empty,
  output logic                desc_last,
  output logic [AW-1:0]       desc_start,
  output logic [CW-1:0]       desc_count,
  output logic [STRIDE_W-1:0] desc_stride
);
  localparam logic [IDX_W-1:0] IDX_NEXT  = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_START = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_COUNT = IDX_W'(2);
  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(DESC_WORDS - 1);
  localparam int unsigned      PAD_W     = AW - IDX_W - 2;

  logic [IDX_W-1:0] idx_q, idx_d;
  logic [AW-1:0]    ptr_q, ptr_d;
  logic [AW-1:0]    next_q, next_d;
  logic [AW-1:0]    start_q, start_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             cap;

  always_comb begin
    cap        = in_fetch && rd_valid;
    fetch_last = cap && (idx_q == IDX_LAST);
    rd_req     = in_fetch;
    rd_addr    = ptr_q + {{PAD_W{1'b0}}, idx_q, 2'b00};
    desc_empty = (cnt_q == '0);
    desc_last  = rd_data[DESC_LAST_BIT];
    desc_stride = rd_data[STRIDE_W-1:0];
    desc_start = start_q;
    desc_count = cnt_q;

    idx_d   = idx_q;
    ptr_d   = ptr_q;
    next_d  = next_q;
    start_d = start_q;
    cnt_d   = cnt_q;
    if (fetch_start) begin
      idx_d = '0;
      ptr_d = first_ptr;
    end else if (cap) begin
      idx_d = idx_q + IDX_W'(1);
      unique case (idx_q)
        IDX_NEXT:  next_d  = rd_data[AW-1:0];
        IDX_START: start_d = rd_data[AW-1:0];
        IDX_COUNT: cnt_d   = rd_data[CW-1:0];
        default:   ptr_d   = next_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      ptr_q   <= '0;
      next_q  <= '0;
      start_q <= '0;
      cnt_q   <= '0;
    end else if (fetch_start || cap) begin
      idx_q   <= idx_d;
      ptr_q   <= ptr_d;
      next_q  <= next_d;
      start_q <= start_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/dma_seq_datapath.sv
module dma_seq_datapath
  import dma_seq_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_cfg,
  input  logic                load_desc,
  input  logic                beat_fire,
  input  logic                reload_mode,
  input  logic [AW-1:0]       cfg_addr,
  input  logic [CW-1:0]       cfg_count,
  input  logic [STRIDE_W-1:0] cfg_stride,
  input  logic [AW-1:0]       desc_start,
  input  logic [CW-1:0]       desc_count,
  input  logic [STRIDE_W-1:0] desc_stride,
  output logic [AW-1:0]       addr_q,
  output logic                count_is_one
);
  localparam int unsigned EXT_W = AW - STRIDE_W;

  logic [AW-1:0]       addr_d, base_addr_q, base_addr_d;
  logic [CW-1:0]       cnt_q, cnt_d, base_cnt_q, base_cnt_d;
  logic [STRIDE_W-1:0] stride_q, stride_d;
  logic [AW-1:0]       stride_ext;
  logic                upd, upd_base;

  always_comb begin
    stride_ext   = {{EXT_W{stride_q[STRIDE_W-1]}}, stride_q};
    count_is_one = (cnt_q == CW'(1));
    upd          = load_cfg || load_desc || beat_fire;
    upd_base     = load_cfg || load_desc;

    addr_d      = addr_q;
    cnt_d       = cnt_q;
    stride_d    = stride_q;
    base_addr_d = base_addr_q;
    base_cnt_d  = base_cnt_q;
    if (load_cfg) begin
      addr_d      = cfg_addr;
      cnt_d       = cfg_count;
      stride_d    = cfg_stride;
      base_addr_d = cfg_addr;
      base_cnt_d  = cfg_count;
    end else if (load_desc) begin
      addr_d      = desc_start;
      cnt_d       = desc_count;
      stride_d    = desc_stride;
      base_addr_d = desc_start;
      base_cnt_d  = desc_count;
    end else if (beat_fire) begin
      if (count_is_one && reload_mode) begin
        addr_d = base_addr_q;
        cnt_d  = base_cnt_q;
      end else begin
        addr_d = addr_q + stride_ext;
        cnt_d  = cnt_q - CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      cnt_q    <= '0;
      stride_q <= '0;
    end else if (upd) begin
      addr_q   <= addr_d;
      cnt_q    <= cnt_d;
      stride_q <= stride_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr_q <= '0;
      base_cnt_q  <= '0;
    end else if (upd_base) begin
      base_addr_q <= base_addr_d;
      base_cnt_q  <= base_cnt_d;
    end
  end
endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq
  import dma_seq_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_start,
  input  logic                cfg_disable,
  input  logic [1:0]          cfg_mode,
  input  logic [AW-1:0]       cfg_addr,
  input  logic [CW-1:0]       cfg_count,
  input  logic [STRIDE_W-1:0] cfg_stride,
  input  logic [AW-1:0]       cfg_desc_ptr,
  input  logic                beat,
  output logic                addr_valid,
  output logic [AW-1:0]       addr,
  output logic                done_irq,
  output logic                full_irq,
  output logic                active,
  output logic                rd_req,
  output logic [AW-1:0]       rd_addr,
  input  logic                rd_valid,
  input  logic [WORD_W-1:0]   rd_data
);
  seq_state_e          state_q;
  seq_mode_e           mode_q;
  logic                load_cfg, load_desc, fetch_start, beat_fire, term_beat;
  logic                count_is_one, fetch_last, desc_empty, desc_last;
  logic [AW-1:0]       desc_start;
  logic [CW-1:0]       desc_count;
  logic [STRIDE_W-1:0] desc_stride;
  logic                reload_mode, in_fetch;

  always_comb begin
    reload_mode = (mode_q == MODE_RELOAD) || (mode_q == MODE_CIRC);
    in_fetch    = (state_q == ST_FETCH);
    addr_valid  = (state_q == ST_RUN);
    active      = (state_q != ST_IDLE);
    done_irq    = term_beat && (mode_q != MODE_CIRC);
    full_irq    = term_beat && (mode_q == MODE_CIRC);
  end

  dma_seq_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (cfg_start),
    .disable_req    (cfg_disable),
    .mode_in        (cfg_mode),
    .cfg_count_zero (cfg_count == '0),
    .beat           (beat),
    .count_is_one   (count_is_one),
    .fetch_last     (fetch_last),
    .desc_empty     (desc_empty),
    .desc_last      (desc_last),
    .state_q        (state_q),
    .mode_q         (mode_q),
    .load_cfg       (load_cfg),
    .load_desc      (load_desc),
    .fetch_start    (fetch_start),
    .beat_fire      (beat_fire),
    .term_beat      (term_beat)
  );

  dma_seq_fetch #(.AW(AW), .CW(CW)) u_fetch (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_start (fetch_start),
    .first_ptr   (cfg_desc_ptr),
    .in_fetch    (in_fetch),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .rd_req      (rd_req),
    .rd_addr     (rd_addr),
    .fetch_last  (fetch_last),
    .desc_empty  (desc_empty),
    .desc_last   (desc_last),
    .desc_start  (desc_start),
    .desc_count  (desc_count),
    .desc_stride (desc_stride)
  );

  dma_seq_datapath #(.AW(AW), .CW(CW)) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_cfg     (load_cfg),
    .load_desc    (load_desc),
    .beat_fire    (beat_fire),
    .reload_mode  (reload_mode),
    .cfg_addr     (cfg_addr),
    .cfg_count    (cfg_count),
    .cfg_stride   (cfg_stride),
    .desc_start   (desc_start),
    .desc_count   (desc_count),
    .desc_stride  (desc_stride),
    .addr_q       (addr),
    .count_is_one (count_is_one)
  );
endmodule

// File: rtl/dma_addr_seq_chk.sv
module dma_addr_seq_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_start,
  input logic          cfg_disable,
  input logic          beat,
  input logic          addr_valid,
  input logic [AW-1:0] addr,
  input logic          done_irq,
  input logic          full_irq,
  input logic          active,
  input logic          rd_req,
  input logic [AW-1:0] rd_addr,
  input logic          rd_valid
);
  assert_hold_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !beat) |=> (addr_valid && $stable(addr)));

  assert_irq_on_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_irq || full_irq) |-> (addr_valid && beat));

  assert_irq_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({done_irq, full_irq}) <= 1);

  assert_disable_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_disable && addr_valid && beat) |=> !active);

  assert_start_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(cfg_start));

  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

  assert_no_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_req, addr_valid}));
endmodule

bind dma_addr_seq dma_addr_seq_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_start   (cfg_start),
  .cfg_disable (cfg_disable),
  .beat        (beat),
  .addr_valid  (addr_valid),
  .addr        (addr),
  .done_irq    (done_irq),
  .full_irq    (full_irq),
  .active      (active),
  .rd_req      (rd_req),
  .rd_addr     (rd_addr),
  .rd_valid    (rd_valid)
);

// File: tb/dma_addr_seq_tb_top.sv
module dma_addr_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 150000;

  logic        clk, rst_n;
  logic        cfg_start, cfg_disable, beat, rd_valid;
  logic [1:0]  cfg_mode;
  logic [31:0] cfg_addr, cfg_desc_ptr, rd_data;
  logic [15:0] cfg_count, cfg_stride;
  logic        addr_valid, done_irq, full_irq, active, rd_req;
  logic [31:0] addr, rd_addr;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [31:0] mem [0:63];
  logic [31:0] q_addr[$];
  bit          q_done[$];
  bit          q_full[$];

  dma_addr_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_disable(cfg_disable),
    .cfg_mode(cfg_mode), .cfg_addr(cfg_addr), .cfg_count(cfg_count),
    .cfg_stride(cfg_stride), .cfg_desc_ptr(cfg_desc_ptr), .beat(beat),
    .addr_valid(addr_valid), .addr(addr), .done_irq(done_irq), .full_irq(full_irq),
    .active(active), .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
    .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] step(input logic [31:0] a, input logic [15:0] s);
    return a + {{16{s[15]}}, s};
  endfunction

  // Memory read responder with random stalls
  initial begin
    rd_valid = 1'b0;
    rd_data  = '0;
    forever begin
      @(negedge clk);
      rd_valid = rd_req && (($urandom % 3) != 0);
      rd_data  = mem[rd_addr[7:2]];
    end
  end

  // Push one pass set: total beats over a buffer of c beats
  task automatic plan_reg(input logic [31:0] a, input int c, input logic [15:0] s,
                          input int total, input bit circ);
    logic [31:0] cur = a;
    for (int k = 0; k < total; k++) begin
      int p = k % c;
      if (p == 0) cur = a;
      q_addr.push_back(cur);
      q_done.push_back((p == c - 1) && !circ);
      q_full.push_back((p == c - 1) && circ);
      cur = step(cur, s);
    end
  endtask

  task automatic run_expect(input bit dis_last, input bit poke);
    int it = 0;
    while (q_addr.size() > 0) begin
      @(negedge clk);
      cfg_start   = 1'b0;
      cfg_disable = 1'b0;
      beat = (($urandom % 4) != 0);
      if (poke && it == 2) begin
        cfg_start = 1'b1;
        cfg_mode  = 2'b00;
        cfg_addr  = 32'hDEAD_0000;
        cfg_count = 16'd5;
      end
      if (dis_last && q_addr.size() == 1 && beat && addr_valid) cfg_disable = 1'b1;
      #1;
      if (addr_valid && beat) begin
        logic [31:0] ea = q_addr.pop_front();
        bit ed = q_done.pop_front();
        bit ef = q_full.pop_front();
        chk(addr == ea, "R2 R3 R5 R7 addr", addr, ea);
        chk(done_irq == ed, "R4 done_irq", {31'b0, done_irq}, {31'b0, ed});
        chk(full_irq == ef, "R6 full_irq", {31'b0, full_irq}, {31'b0, ef});
      end else begin
        chk(!(done_irq || full_irq), "R4 irq without beat", {30'b0, done_irq, full_irq}, 0);
      end
      it++;
    end
    @(negedge clk);
    beat = 1'b0; cfg_disable = 1'b0; cfg_start = 1'b0;
  endtask

  task automatic start_reg(input logic [1:0] m, input logic [31:0] a,
                           input logic [15:0] c, input logic [15:0] s);
    @(negedge clk);
    cfg_mode = m; cfg_addr = a; cfg_count = c; cfg_stride = s; cfg_start = 1'b1;
    beat = 1'b0;
  endtask

  task automatic put_desc(input int base, input logic [31:0] nxt, input logic [31:0] st,
                          input logic [31:0] cnt, input logic [15:0] s, input bit last);
    mem[base]   = nxt;
    mem[base+1] = st;
    mem[base+2] = cnt;
    mem[base+3] = {15'b0, last, s};
  endtask

  // After a run that finished normally: DONE then IDLE
  task automatic expect_wind_down(input string req);
    #1;
    chk(!addr_valid, req, {31'b0, addr_valid}, 0);
    @(negedge clk); #1;
    chk(!active, req, {31'b0, active}, 0);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; cfg_start = 0; cfg_disable = 0; beat = 0;
    cfg_mode = 0; cfg_addr = 0; cfg_count = 0; cfg_stride = 0; cfg_desc_ptr = 0;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(!active && !addr_valid && !rd_req && !done_irq && !full_irq, "R1 reset outputs",
        {27'b0, active, addr_valid, rd_req, done_irq, full_irq}, 0);

    // R10: zero count start ignored
    start_reg(2'b00, 32'h100, 16'd0, 16'd4);
    @(negedge clk); cfg_start = 0;
    repeat (2) @(negedge clk);
    #1 chk(!active, "R10 zero count start ignored", {31'b0, active}, 0);

    // Directed: zero stride linear, large negative stride wraparound
    start_reg(2'b00, 32'h0000_0040, 16'd3, 16'd0);
    plan_reg(32'h40, 3, 16'd0, 3, 0);
    run_expect(0, 0);
    expect_wind_down("R2 linear stop");
    start_reg(2'b00, 32'h0000_0004, 16'd3, 16'h8000);
    plan_reg(32'h4, 3, 16'h8000, 3, 0);
    run_expect(0, 0);
    expect_wind_down("R2 linear stop");

    // Directed: reload with start pokes mid-run (R10), single-beat circular (R6)
    start_reg(2'b01, 32'h0000_0200, 16'd3, 16'd4);
    plan_reg(32'h200, 3, 16'd4, 7, 0);
    run_expect(1, 1);
    #1 chk(!active, "R9 disable at beat", {31'b0, active}, 0);
    start_reg(2'b10, 32'hFFFF_FFF0, 16'd1, 16'hFFFF);
    plan_reg(32'hFFFF_FFF0, 1, 16'hFFFF, 4, 1);
    run_expect(1, 0);
    #1 chk(!active, "R9 disable at beat", {31'b0, active}, 0);

    // Random register-mode runs
    for (int t = 0; t < 40; t++) begin
      logic [1:0]  m = 2'($urandom % 3);
      logic [31:0] a = $urandom;
      int          c = 1 + ($urandom % 6);
      logic [15:0] s;
      int          r = $urandom % 5;
      if (r == 0)      s = 16'd0;
      else if (r == 1) s = 16'($urandom);
      else             s = 16'(int'($urandom % 33) - 16);
      start_reg(m, a, 16'(c), s);
      if (m == 2'b00) begin
        plan_reg(a, c, s, c, 0);
        run_expect(0, 0);
        expect_wind_down("R2 linear stop");
      end else begin
        plan_reg(a, c, s, 2 * c + 1, m == 2'b10);
        run_expect(1, (t % 3) == 0);
        #1 chk(!active, "R9 disable at beat", {31'b0, active}, 0);
      end
    end

    // Chained mode: three sets, the middle one empty (R7, R8)
    put_desc(16, 32'h80, 32'h1000, 32'd3, 16'hFFFC, 0);
    put_desc(32, 32'hC0, 32'h2000, 32'd0, 16'd8, 0);
    put_desc(48, 32'h0,  32'h3000, 32'd2, 16'd0, 1);
    @(negedge clk);
    cfg_mode = 2'b11; cfg_desc_ptr = 32'h40; cfg_start = 1'b1;
    plan_reg(32'h1000, 3, 16'hFFFC, 3, 0);
    plan_reg(32'h3000, 2, 16'd0, 2, 0);
    run_expect(0, 0);
    expect_wind_down("R7 chain ends at last set");

    // Random chains
    for (int t = 0; t < 12; t++) begin
      for (int d = 0; d < 3; d++) begin
        logic [31:0] st  = $urandom;
        int          cn  = (d == 1 && (t % 2) == 0) ? 0 : 1 + ($urandom % 4);
        logic [15:0] s   = 16'(int'($urandom % 65) - 32);
        put_desc(16 + 16 * d, 32'h80 + 32'(d) * 32'h40, st, 32'(cn), s, d == 2);
        if (cn > 0) plan_reg(st, cn, s, cn, 0);
      end
      @(negedge clk);
      cfg_mode = 2'b11; cfg_desc_ptr = 32'h40; cfg_start = 1'b1;
      run_expect(0, 0);
      expect_wind_down("R8 R7 random chain");
    end

    // Disable during fetch: no address ever presented (R9)
    begin
      bit saw = 0;
      @(negedge clk);
      cfg_mode = 2'b11; cfg_desc_ptr = 32'h40; cfg_start = 1'b1;
      @(negedge clk);
      cfg_start = 1'b0; cfg_disable = 1'b1;
      @(negedge clk);
      cfg_disable = 1'b0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk); #1;
        if (addr_valid) saw = 1;
      end
      chk(!saw, "R9 disable during fetch no beats", {31'b0, saw}, 0);
      chk(!active, "R9 disable during fetch idle", {31'b0, active}, 0);
    end

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule